// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes one x16 DDR3 SDRAM from power-on to its idle state. It drives the device pins at command level, one command per controller clock. It holds the memory reset low for a set time and then releases it. It waits again before raising clock enable, and waits a third time before the first mode-register write. It then programs the four mode registers, issues one long ZQ calibration, waits out the calibration time and raises `init_done`.

All delays are parameters counted in clock cycles. The defaults suit a 250 MHz controller clock: 200 us of reset hold, 500 us before clock enable, 4-clock and 12-clock mode-register spacing, and 512 clocks of calibration time. A simulation can shrink these values and still check the order and spacing of the commands. CAS latency, CAS write latency and write recovery are parameters, and the mode-register words are derived from them. Every cycle that carries no command drives a NOP, and the termination pin stays low throughout. A synchronous reset that arrives at any point restarts the whole sequence.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high, after the following clock edge: `mem_rst_n`=0, `mem_cke`=0, NOP on the command pins (`mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=1), `mem_ba`=0, `mem_addr`=0, `mem_odt`=0, `init_done`=0. A reset arriving mid-sequence returns to this state.
- R2: After `rst` is released, `mem_rst_n` reads low for exactly RST_HOLD_CYC clock cycles. It then goes high and stays high.
- R3: `mem_cke` goes high exactly CKE_WAIT_CYC cycles after `mem_rst_n` goes high.
- R4: The first mode-register write (MRS: cs/ras/cas/we = 0/0/0/0) comes exactly XPR_CYC cycles after `mem_cke` rises. Exactly four are issued, with bank addresses 2, 3, 1, 0 in that order.
- R5: Successive mode-register writes are exactly MRD_CYC cycles apart.
- R6: The bank-2 word has CAS write latency code CWL-5 in A[5:3] and all other bits zero. With CWL=6 this is 0x0008: full-array self-refresh, auto self-refresh off, normal temperature range, dynamic termination off.
- R7: The bank-3 word is 0x0000: the multipurpose register is off and the predefined pattern is selected.
- R8: The bank-1 word is 0x0044. A2 and A6 are set (40 ohm nominal termination). A0=0 keeps the DLL enabled. A1/A5=0 selects 40 ohm drive. A3, A4, A7, A11 and A12 are zero: additive latency 0, write leveling off, TDQS off, outputs enabled.
- R9: The bank-0 word is 0x1930 for CL=7 and WR=8. A[1:0]=00 selects burst length 8, A3=0 selects sequential order, A[6:4]=011 with A2=0 selects CL 7, A8=1 resets the DLL, A[11:9]=100 selects write recovery 8, and A12=1 selects DLL-on power-down.
- R10: The long ZQ calibration (cs/ras/cas/we = 0/1/1/0, A10=1, other address bits 0, bank 0) comes exactly MOD_CYC cycles after the bank-0 write.
- R11: `init_done` rises exactly ZQINIT_CYC cycles after the calibration command and then stays high. Only NOPs follow.
- R12: Exactly five non-NOP commands are issued per sequence. In every NOP cycle, `mem_ba` and `mem_addr` are zero. `mem_odt` is never high, and no command appears while `mem_cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one command slot per cycle |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mem_rst_n | output | 1 | Active-low memory reset |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address, selects the mode register |
| mem_addr | output | ADDR_W | Address bus, carries mode-register words |
| mem_odt | output | 1 | On-die termination enable, held low |
| init_done | output | 1 | High once initialization has finished |

## Verification
The hardest situation to reach from the ports is a reset landing in the middle of the sequence. Examples are a reset between two mode-register writes, during the calibration wait, or one cycle before `init_done`. The device must then drop back to a clean power-up state and not resume half-way. The stimulus releases reset and re-asserts it after a number of cycles. That number is picked at directed points next to each command and at random points from a fixed seed. The bench checks the reset state each time, then runs and measures a complete sequence.

// File: rtl/ddr3_init_pkg.sv
`timescale 1ns/1ps
package ddr3_init_pkg;

    localparam int BA_W    = 3;
    localparam int MR_STEPS = 4;

    typedef enum logic [2:0] {
        ST_RST  = 3'd0,
        ST_CKE  = 3'd1,
        ST_XPR  = 3'd2,
        ST_MRS  = 3'd3,
        ST_ZQ   = 3'd4,
        ST_DONE = 3'd5
    } init_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t CMD_ZQCL = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    typedef struct packed {
        logic            rst_n;
        logic            cke;
        cmd_pins_t       cmd;
        logic [BA_W-1:0] ba;
        logic            odt;
        logic            done;
    } ctl_pins_t;

    localparam ctl_pins_t CTL_IDLE = '{rst_n: 1'b0, cke: 1'b0, cmd: CMD_NOP,
                                       ba: '0, odt: 1'b0, done: 1'b0};

    localparam logic [15:0] ZQ_LONG_ADDR = 16'h0400;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // CAS write latency field, valid for 5..8
    function automatic logic [2:0] cwl_code(input int cwl);
        return 3'(cwl - 5);
    endfunction

    // CAS latency field A[6:4], valid for 5..11 (A2 stays 0)
    function automatic logic [2:0] cl_code(input int cl);
        return 3'(cl - 4);
    endfunction

    // Write recovery field A[11:9]
    function automatic logic [2:0] wr_code(input int wr);
        if (wr <= 8)       return 3'(wr - 4);
        else if (wr == 16) return 3'd0;
        else               return 3'(wr / 2);
    endfunction

    // Programming order: step 0..3 targets banks 2,3,1,0
    function automatic logic [BA_W-1:0] mr_bank(input int step);
        case (step)
            0:       return BA_W'(2);
            1:       return BA_W'(3);
            2:       return BA_W'(1);
            default: return BA_W'(0);
        endcase
    endfunction

    function automatic logic [15:0] mr_addr(input int step, input int cl,
                                            input int cwl, input int wr);
        logic [15:0] a;
        a = '0;
        case (step)
            0: a[5:3] = cwl_code(cwl);
            2: begin
                a[2] = 1'b1;
                a[6] = 1'b1;
            end
            3: begin
                a[6:4]  = cl_code(cl);
                a[8]    = 1'b1;
                a[11:9] = wr_code(wr);
                a[12]   = 1'b1;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dis_timer.sv
`timescale 1ns/1ps
module dis_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= CNT_W'(RST_VAL);
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dis_mr_table.sv
`timescale 1ns/1ps
module dis_mr_table
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CL     = 7,
    parameter int CWL    = 6,
    parameter int WR     = 8
) (
    input  logic [1:0]        step,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [BA_W-1:0]   ba_tbl [MR_STEPS];
    logic [ADDR_W-1:0] ad_tbl [MR_STEPS];

    for (genvar g = 0; g < MR_STEPS; g++) begin : g_mr
        assign ba_tbl[g] = mr_bank(g);
        assign ad_tbl[g] = ADDR_W'(mr_addr(g, CL, CWL, WR));
    end

    assign ba   = ba_tbl[step];
    assign addr = ad_tbl[step];
endmodule

// File: rtl/dis_pin_reg.sv
`timescale 1ns/1ps
module dis_pin_reg
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_pins_t         ctl_d,
    input  logic [ADDR_W-1:0] addr_d,
    output ctl_pins_t         ctl_q,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_IDLE;
            addr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/ddr3_init_seq.sv
`timescale 1ns/1ps
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int RST_HOLD_CYC = 50000,
    parameter int CKE_WAIT_CYC = 125000,
    parameter int XPR_CYC      = 72,
    parameter int MRD_CYC      = 4,
    parameter int MOD_CYC      = 12,
    parameter int ZQINIT_CYC   = 512,
    parameter int CL           = 7,
    parameter int CWL          = 6,
    parameter int WR           = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_odt,
    output logic              init_done
);
    localparam int MAX_CYC = max2(max2(max2(RST_HOLD_CYC, CKE_WAIT_CYC),
                                       max2(XPR_CYC, MRD_CYC)),
                                  max2(MOD_CYC, ZQINIT_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    init_st_e         state_q, state_d;
    logic [1:0]       step_q, step_d;
    logic             first_q;
    logic             expired;
    logic             advance;
    logic [CNT_W-1:0] span_d;
    logic [BA_W-1:0]  mr_ba;
    logic [ADDR_W-1:0] mr_ad;
    ctl_pins_t        ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    // Cycles spent in a phase, minus one, as loaded into the timer
    function automatic logic [CNT_W-1:0] span(input init_st_e st, input logic [1:0] stp);
        case (st)
            ST_RST:  return CNT_W'(RST_HOLD_CYC - 1);
            ST_CKE:  return CNT_W'(CKE_WAIT_CYC - 1);
            ST_XPR:  return CNT_W'(XPR_CYC - 1);
            ST_MRS:  return (stp == 2'd3) ? CNT_W'(MOD_CYC - 1) : CNT_W'(MRD_CYC - 1);
            ST_ZQ:   return CNT_W'(ZQINIT_CYC - 1);
            default: return '0;
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        if (expired) begin
            case (state_q)
                ST_RST: state_d = ST_CKE;
                ST_CKE: state_d = ST_XPR;
                ST_XPR: begin
                    state_d = ST_MRS;
                    step_d  = 2'd0;
                end
                ST_MRS: begin
                    if (step_q == 2'd3) state_d = ST_ZQ;
                    else                step_d  = step_q + 2'd1;
                end
                ST_ZQ:   state_d = ST_DONE;
                default: state_d = ST_DONE;
            endcase
        end
    end

    assign advance = expired && (state_q != ST_DONE);
    assign span_d  = span(state_d, step_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RST;
            step_q  <= 2'd0;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            first_q <= advance;
        end
    end

    dis_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_HOLD_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (span_d),
        .expired  (expired)
    );

    dis_mr_table #(
        .ADDR_W (ADDR_W),
        .CL     (CL),
        .CWL    (CWL),
        .WR     (WR)
    ) u_mr_table (
        .step (step_q),
        .ba   (mr_ba),
        .addr (mr_ad)
    );

    always_comb begin
        ctl_d       = CTL_IDLE;
        addr_d      = '0;
        ctl_d.rst_n = (state_q != ST_RST);
        ctl_d.cke   = (state_q != ST_RST) && (state_q != ST_CKE);
        ctl_d.done  = (state_q == ST_DONE);
        if (state_q == ST_MRS && first_q) begin
            ctl_d.cmd = CMD_MRS;
            ctl_d.ba  = mr_ba;
            addr_d    = mr_ad;
        end else if (state_q == ST_ZQ && first_q) begin
            ctl_d.cmd = CMD_ZQCL;
            addr_d    = ADDR_W'(ZQ_LONG_ADDR);
        end
    end

    dis_pin_reg #(
        .ADDR_W (ADDR_W)
    ) u_pins (
        .clk    (clk),
        .rst    (rst),
        .ctl_d  (ctl_d),
        .addr_d (addr_d),
        .ctl_q  (ctl_q),
        .addr_q (addr_q)
    );

    assign mem_rst_n = ctl_q.rst_n;
    assign mem_cke   = ctl_q.cke;
    assign mem_cs_n  = ctl_q.cmd.cs_n;
    assign mem_ras_n = ctl_q.cmd.ras_n;
    assign mem_cas_n = ctl_q.cmd.cas_n;
    assign mem_we_n  = ctl_q.cmd.we_n;
    assign mem_ba    = ctl_q.ba;
    assign mem_addr  = addr_q;
    assign mem_odt   = ctl_q.odt;
    assign init_done = ctl_q.done;
endmodule

// File: rtl/ddr3_init_seq_chk.sv
`timescale 1ns/1ps
module ddr3_init_seq_chk #(
    parameter int MRD_CYC = 4,
    parameter int MOD_CYC = 12
) (
    input logic clk,
    input logic rst,
    input logic mem_rst_n,
    input logic mem_cke,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic mem_odt,
    input logic init_done
);
    logic [3:0]  cmd;
    logic        is_nop, is_mrs, is_zq;
    logic [15:0] gap_q;
    logic [2:0]  mrs_cnt_q;

    assign cmd    = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign is_nop = (cmd == 4'b0111);
    assign is_mrs = (cmd == 4'b0000);
    assign is_zq  = (cmd == 4'b0110);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            mrs_cnt_q <= '0;
        end else begin
            if (is_mrs)               gap_q <= 16'd1;
            else if (gap_q != 16'hFFFF && gap_q != 16'd0) gap_q <= gap_q + 16'd1;
            if (is_mrs && mrs_cnt_q != 3'd7) mrs_cnt_q <= mrs_cnt_q + 3'd1;
        end
    end

    assert_rst_n_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rst_n |=> mem_rst_n);

    assert_cmd_needs_cke_R12: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> (mem_cke && mem_rst_n));

    assert_odt_low_R12: assert property (@(posedge clk) disable iff (rst)
        !mem_odt);

    assert_legal_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_mrs || is_zq);

    assert_mrd_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (is_mrs && gap_q != 16'd0) |-> (gap_q >= 16'(MRD_CYC)));

    assert_zq_after_four_R4: assert property (@(posedge clk) disable iff (rst)
        is_zq |-> (mrs_cnt_q == 3'd4));

    assert_zq_mod_gap_R10: assert property (@(posedge clk) disable iff (rst)
        is_zq |-> (gap_q >= 16'(MOD_CYC)));

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(
    .MRD_CYC (MRD_CYC),
    .MOD_CYC (MOD_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rst_n (mem_rst_n),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_odt   (mem_odt),
    .init_done (init_done)
);

// File: tb/ddr3_init_seq_bench.sv
`timescale 1ns/1ps
module ddr3_init_seq_bench;
    localparam int AW   = 14;
    localparam int RSTC = 20;
    localparam int CKEC = 30;
    localparam int XPRC = 10;
    localparam int MRDC = 4;
    localparam int MODC = 12;
    localparam int ZQC  = 40;
    localparam int CLV  = 7;
    localparam int CWLV = 6;
    localparam int WRV  = 8;
    localparam int LAST = RSTC + 1 + CKEC + XPRC + 3*MRDC + MODC + ZQC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_rst_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [2:0]    mem_ba;
    logic [AW-1:0] mem_addr;
    logic mem_odt, init_done;

    always #2 clk = ~clk;

    ddr3_init_seq #(
        .ADDR_W(AW), .RST_HOLD_CYC(RSTC), .CKE_WAIT_CYC(CKEC), .XPR_CYC(XPRC),
        .MRD_CYC(MRDC), .MOD_CYC(MODC), .ZQINIT_CYC(ZQC),
        .CL(CLV), .CWL(CWLV), .WR(WRV)
    ) u_ddr3_init_seq (
        .clk(clk), .rst(rst), .mem_rst_n(mem_rst_n), .mem_cke(mem_cke),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
        .mem_odt(mem_odt), .init_done(init_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected mode-register words, built from the field rules in R6..R9
    function automatic int exp_word(input int idx);
        case (idx)
            0:       return (CWLV - 5) << 3;
            1:       return 0;
            2:       return (1 << 2) | (1 << 6);
            default: return (1 << 12) | ((WRV - 4) << 9) | (1 << 8) | ((CLV - 4) << 4);
        endcase
    endfunction

    task automatic check_reset(input string tag);
        chk("R1", {tag, " rst_n"}, int'(mem_rst_n), 0);
        chk("R1", {tag, " cke"},   int'(mem_cke), 0);
        chk("R1", {tag, " cmd"},   int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 7);
        chk("R1", {tag, " ba"},    int'(mem_ba), 0);
        chk("R1", {tag, " addr"},  int'(mem_addr), 0);
        chk("R1", {tag, " odt"},   int'(mem_odt), 0);
        chk("R1", {tag, " done"},  int'(init_done), 0);
    endtask

    task automatic full_run(input int tail);
        int rr = -1;
        int cr = -1;
        int dr = -1;
        int nc = 0;
        int drops = 0;
        int odt_cnt = 0;
        int dirty = 0;
        int cy[8];
        int kd[8];
        int bk[8];
        int ad[8];
        logic [3:0] kind;
        for (int i = 0; i < 8; i++) begin
            cy[i] = -1; kd[i] = -1; bk[i] = -1; ad[i] = -1;
        end
        rst = 1'b0;
        for (int k = 1; k <= LAST + tail; k++) begin
            @(negedge clk);
            if (mem_rst_n && rr < 0) rr = k;
            if (!mem_rst_n && rr >= 0) drops++;
            if (mem_cke && cr < 0) cr = k;
            if (init_done && dr < 0) dr = k;
            if (!init_done && dr >= 0) drops++;
            if (mem_odt) odt_cnt++;
            kind = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
            if (kind != 4'b0111) begin
                if (nc < 8) begin
                    cy[nc] = k; kd[nc] = int'(kind); bk[nc] = int'(mem_ba); ad[nc] = int'(mem_addr);
                end
                nc++;
            end else if (mem_ba != '0 || mem_addr != '0) begin
                dirty++;
            end
        end
        chk("R2", "reset release cycle", rr, RSTC + 1);
        chk("R2", "rst_n or done dropped", drops, 0);
        chk("R3", "cke delay", cr - rr, CKEC);
        chk("R12", "command count", nc, 5);
        chk("R4", "first MRS delay", cy[0] - cr, XPRC);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "MRS opcode", kd[i], 0);
            chk("R4", "MRS bank order", bk[i], (i == 0) ? 2 : (i == 1) ? 3 : (i == 2) ? 1 : 0);
        end
        for (int i = 0; i < 3; i++) chk("R5", "MRS spacing", cy[i+1] - cy[i], MRDC);
        chk("R6", "bank2 word", ad[0], exp_word(0));
        chk("R6", "bank2 literal", ad[0], 'h0008);
        chk("R7", "bank3 word", ad[1], exp_word(1));
        chk("R8", "bank1 word", ad[2], 'h0044);
        chk("R9", "bank0 word", ad[3], 'h1930);
        chk("R9", "bank0 fields", ad[3], exp_word(3));
        chk("R10", "ZQCL opcode", kd[4], 6);
        chk("R10", "ZQCL address", ad[4], 'h0400);
        chk("R10", "ZQCL bank", bk[4], 0);
        chk("R10", "ZQCL spacing", cy[4] - cy[3], MODC);
        chk("R11", "done delay", dr - cy[4], ZQC);
        chk("R12", "odt high cycles", odt_cnt, 0);
        chk("R12", "NOP with nonzero ba/addr", dirty, 0);
    endtask

    task automatic abort_at(input int r);
        rst = 1'b0;
        repeat (r) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset($sformatf("R1 abort at %0d", r));
    endtask

    initial begin
        int unsigned seed_init;
        int dir_pts[5];
        seed_init = $urandom(32'd20517);
        dir_pts[0] = 1;
        dir_pts[1] = RSTC + 1 + CKEC + XPRC + MRDC + 1;
        dir_pts[2] = RSTC + 1 + CKEC + XPRC + 3*MRDC + 2;
        dir_pts[3] = LAST - 1;
        dir_pts[4] = RSTC + 1 + CKEC;
        repeat (3) @(negedge clk);
        check_reset("R1 power-on");
        full_run(20);
        for (int it = 0; it < 11; it++) begin
            int r;
            if (it < 5) r = dir_pts[it];
            else        r = int'($urandom_range(LAST + 4, 1));
            rst = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check_reset("R1 before abort");
            abort_at(r);
            full_run(10);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R11 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule